// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU Step With Flags

This block executes the register-to-accumulator arithmetic and logic group of a small 8-bit processor. It takes an instruction byte, the current accumulator, the current flag byte, a flattened copy of the six general registers and a memory read-data bus. It returns write strobes and write data for the accumulator and the flag byte, plus a one-cycle strobe that tells the sequencer to advance the program counter. The accumulator and flag storage stay in the surrounding core. This block holds only the short sequence that fetches a memory operand.

An instruction byte is taken when `instr_valid` is high and the block is idle. Bits 7:6 of the byte must be `10`. Bits 5:3 select one of eight operations and bits 2:0 select the source operand. A register operand is handled in one step. A memory operand first drives one read cycle at the address formed by the H and L registers, and completes on the cycle after that using the returned byte. All outputs are registered.

Top module: `acc_alu_unit`

## Requirements
- R1: A byte offered with `instr_valid` high is taken only if its bits 7:6 are `10` and the block is idle. Any other byte causes no strobe at all. Bits 5:3 encode the operation: add 000, add-with-carry 001, subtract 010, subtract-with-borrow 011, and 100, xor 101, or 110, compare 111.
- R2: Bits 2:0 encode the source operand: B 000, C 001, D 010, E 011, H 100, L 101, the memory byte at {H,L} 110, and the accumulator 111. In `gpr_flat`, the register with code k sits in bits [8k+7:8k] for k from 0 to 5.
- R3: With a register source, `pc_inc`, `flag_we` and the result appear in the cycle right after the accepting clock edge. `pc_inc` is high for exactly that one cycle.
- R4: With the memory source, the cycle after acceptance has `mem_rd` high, `mem_addr` equal to {H,L} and `pc_inc` low. The result and `pc_inc` follow in the next cycle, computed from `mem_rdata` sampled at the end of the read cycle. Any instruction offered during the read cycle is ignored.
- R5: The flag byte holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3:0 of `flag_wdata` copy bits 3:0 of `flags_in`.
- R6: Add and add-with-carry clear N. They set Z on a zero 8-bit result, H on the carry out of the low nibble and C on the carry out of bit 7. Add-with-carry also adds the incoming C flag (bit 4 of `flags_in`) into both the nibble sum and the byte sum.
- R7: Subtract and subtract-with-borrow set N. H is the borrow out of the low nibble and C is the borrow out of the byte. Subtract-with-borrow also subtracts the incoming C flag. Z is set on a zero result.
- R8: Compare produces exactly the flags that subtract would, but leaves `acc_we` low. Every other operation raises `acc_we` together with `flag_we`.
- R9: And sets H and clears C. Xor and or clear both H and C. All three clear N and set Z on a zero result.
- R10: While `rst_n` is low at a clock edge, all outputs go to zero and any pending memory operand is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction byte is offered this cycle |
| instr | input | 8 | Instruction byte |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | 8 | Current flag byte |
| gpr_flat | input | 48 | Registers B, C, D, E, H, L packed as 8-bit fields |
| mem_rdata | input | 8 | Memory read data, valid during the read cycle |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address {H,L} |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 8 | New accumulator value |
| flag_we | output | 1 | Flag byte write strobe |
| flag_wdata | output | 8 | New flag byte |
| pc_inc | output | 1 | Program counter advance strobe, one per instruction |

## Verification
The memory read cycle of one instruction can coincide with the offer of the next instruction byte. The bench presents a second valid byte in the read cycle of a memory-operand add. It then checks that exactly one `pc_inc` follows and that its data matches the first instruction. Reset can also arrive in the same cycle as a pending memory completion. The bench asserts reset during a read cycle and checks that no completion strobe ever appears.

// File: rtl/acc_alu_pkg.sv
// Package: shared encodings of the accumulator ALU group.
// Assumes an 8-bit flag byte with the four status flags in its upper nibble.
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_ADC = 3'b001,
        OP_SUB = 3'b010,
        OP_SBC = 3'b011,
        OP_AND = 3'b100,
        OP_XOR = 3'b101,
        OP_OR  = 3'b110,
        OP_CP  = 3'b111
    } alu_op_e;

    localparam int FLAG_Z = 7;
    localparam int FLAG_N = 6;
    localparam int FLAG_H = 5;
    localparam int FLAG_C = 4;

    localparam logic [1:0] GROUP_TAG = 2'b10;
    localparam logic [2:0] SRC_MEM   = 3'b110;
    localparam logic [2:0] SRC_ACC   = 3'b111;

endpackage

// File: rtl/acc_alu_core.sv
// Module: combinational arithmetic/logic core.
// Takes the accumulator, the operand and the incoming carry flag. Returns the
// result, the four status flags and whether the accumulator is written.
// Assumes DATA_W is even, so that the half-carry nibble is DATA_W/2 wide.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              z_out,
    output logic              n_out,
    output logic              h_out,
    output logic              c_out,
    output logic              writes_acc
);
    localparam int NIB = DATA_W / 2;

    logic              cin_used;
    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   dif_w;
    logic [NIB:0]      sum_n;
    logic [NIB:0]      dif_n;

    // Carry only enters the add-with-carry and subtract-with-borrow forms.
    assign cin_used = carry_in && (op == OP_ADC || op == OP_SBC);

    // Widened sums and differences expose carry and borrow bits.
    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin_used};
        dif_w = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin_used};
        sum_n = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin_used};
        dif_n = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin_used};
    end

    // Result and flag selection per operation.
    always_comb begin
        result     = '0;
        n_out      = 1'b0;
        h_out      = 1'b0;
        c_out      = 1'b0;
        writes_acc = (op != OP_CP);
        unique case (op)
            OP_ADD, OP_ADC: begin
                result = sum_w[DATA_W-1:0];
                h_out  = sum_n[NIB];
                c_out  = sum_w[DATA_W];
            end
            OP_SUB, OP_SBC, OP_CP: begin
                result = dif_w[DATA_W-1:0];
                n_out  = 1'b1;
                h_out  = dif_n[NIB];
                c_out  = dif_w[DATA_W];
            end
            OP_AND: begin
                result = a & b;
                h_out  = 1'b1;
            end
            OP_XOR: result = a ^ b;
            OP_OR:  result = a | b;
            default: result = '0;
        endcase
        z_out = (result == '0);
    end

endmodule

// File: rtl/acc_operand_mux.sv
// Module: source operand selector.
// Unpacks the flattened general registers and picks one register, the
// accumulator or the memory data according to a 3-bit source code.
// Assumes the memory code and the accumulator code are the two top codes.
module acc_operand_mux
    import acc_alu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_GPR = 6
) (
    input  logic [NUM_GPR*DATA_W-1:0] gpr_flat,
    input  logic [DATA_W-1:0]         acc_in,
    input  logic [DATA_W-1:0]         mem_data,
    input  logic [2:0]                src,
    output logic [DATA_W-1:0]         operand
);
    logic [DATA_W-1:0] gpr [NUM_GPR];

    // One unpacked slot per general register.
    for (genvar gi = 0; gi < NUM_GPR; gi++) begin : g_unpack
        assign gpr[gi] = gpr_flat[gi*DATA_W +: DATA_W];
    end

    // Code to operand selection.
    always_comb begin
        if (src == SRC_ACC)
            operand = acc_in;
        else if (src == SRC_MEM)
            operand = mem_data;
        else if (int'(src) < NUM_GPR)
            operand = gpr[src];
        else
            operand = '0;
    end

endmodule

// File: rtl/acc_alu_unit.sv
// Module: top of the accumulator ALU instruction step.
// Decodes an instruction byte of the group tagged 10 in its top bits. It runs
// a register-operand instruction in one step, and spends one read cycle at
// {H,L} on a memory-operand instruction. It then issues registered write
// strobes for the accumulator and the flags, and one program counter pulse.
// Assumes the caller holds acc_in, flags_in and gpr_flat stable until the
// completion strobe, and returns mem_rdata within the read cycle.
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_GPR = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      instr_valid,
    input  logic [7:0]                instr,
    input  logic [DATA_W-1:0]         acc_in,
    input  logic [DATA_W-1:0]         flags_in,
    input  logic [NUM_GPR*DATA_W-1:0] gpr_flat,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      mem_rd,
    output logic [2*DATA_W-1:0]       mem_addr,
    output logic                      acc_we,
    output logic [DATA_W-1:0]         acc_wdata,
    output logic                      flag_we,
    output logic [DATA_W-1:0]         flag_wdata,
    output logic                      pc_inc
);
    localparam int HI_IDX = 4;
    localparam int LO_IDX = 5;

    typedef enum logic {ST_IDLE, ST_MEM} step_e;

    step_e             st_q;
    alu_op_e           op_q;
    alu_op_e           exec_op;
    logic [2:0]        exec_src;
    logic              take;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] result;
    logic              z_f, n_f, h_f, c_f, wr_acc;
    logic [DATA_W-1:0] hi_reg, lo_reg;

    assign hi_reg = gpr_flat[HI_IDX*DATA_W +: DATA_W];
    assign lo_reg = gpr_flat[LO_IDX*DATA_W +: DATA_W];

    // Acceptance of a new byte of this group while idle.
    assign take = instr_valid && (instr[7:6] == GROUP_TAG) && (st_q == ST_IDLE);

    // Operation and source come from the live byte or from the latched op.
    always_comb begin
        if (st_q == ST_MEM) begin
            exec_op  = op_q;
            exec_src = SRC_MEM;
        end else begin
            exec_op  = alu_op_e'(instr[5:3]);
            exec_src = instr[2:0];
        end
    end

    acc_operand_mux #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_mux (
        .gpr_flat (gpr_flat),
        .acc_in   (acc_in),
        .mem_data (mem_rdata),
        .src      (exec_src),
        .operand  (operand)
    );

    acc_alu_core #(.DATA_W(DATA_W)) u_core (
        .op         (exec_op),
        .a          (acc_in),
        .b          (operand),
        .carry_in   (flags_in[FLAG_C]),
        .result     (result),
        .z_out      (z_f),
        .n_out      (n_f),
        .h_out      (h_f),
        .c_out      (c_f),
        .writes_acc (wr_acc)
    );

    // Step sequencer and registered write-back strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            op_q       <= OP_ADD;
            mem_rd     <= 1'b0;
            mem_addr   <= '0;
            acc_we     <= 1'b0;
            acc_wdata  <= '0;
            flag_we    <= 1'b0;
            flag_wdata <= '0;
            pc_inc     <= 1'b0;
        end else begin
            mem_rd  <= 1'b0;
            acc_we  <= 1'b0;
            flag_we <= 1'b0;
            pc_inc  <= 1'b0;
            if ((st_q == ST_IDLE && take && exec_src == SRC_MEM)) begin
                st_q     <= ST_MEM;
                op_q     <= exec_op;
                mem_rd   <= 1'b1;
                mem_addr <= {hi_reg, lo_reg};
            end else if (st_q == ST_MEM || take) begin
                st_q       <= ST_IDLE;
                acc_we     <= wr_acc;
                acc_wdata  <= result;
                flag_we    <= 1'b1;
                flag_wdata <= {z_f, n_f, h_f, c_f, flags_in[3:0]};
                pc_inc     <= 1'b1;
            end
        end
    end

    // R4: the read cycle never carries the completion pulse.
    p_no_done_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !pc_inc);

    // R4: a read cycle lasts one cycle and is followed by completion.
    p_read_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (pc_inc && !mem_rd));

    // R4: the read address is the H:L pair seen at acceptance.
    p_read_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr == {$past(hi_reg), $past(lo_reg)}));

    // R5: the low flag nibble passes through from the sampled flags.
    p_low_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flag_wdata[3:0] == $past(flags_in[3:0])));

    // R8: an accumulator write always comes with a flag write and pc pulse.
    p_acc_with_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (flag_we && pc_inc));

    // R3: every completion has a cause in the previous cycle.
    p_done_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |-> ($past(instr_valid) || $past(mem_rd)));

endmodule

// File: tb/acc_alu_unit_test.sv
module acc_alu_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] src;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] fin;
        logic [7:0] ea;
        logic [7:0] ef;
        logic       ewe;
    } vec_t;

    // op, src, acc, operand(B), flags_in, expected acc, expected flags, acc write
    localparam vec_t VEC [NV] = '{
        {3'd0, 3'd0, 8'h10, 8'h22, 8'h0A, 8'h32, 8'h0A, 1'b1},
        {3'd0, 3'd0, 8'hFF, 8'h01, 8'h05, 8'h00, 8'hB5, 1'b1},
        {3'd0, 3'd0, 8'h08, 8'h08, 8'h00, 8'h10, 8'h20, 1'b1},
        {3'd1, 3'd0, 8'h0F, 8'h00, 8'h10, 8'h10, 8'h20, 1'b1},
        {3'd1, 3'd0, 8'hF0, 8'h0F, 8'h10, 8'h00, 8'hB0, 1'b1},
        {3'd2, 3'd0, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h60, 1'b1},
        {3'd2, 3'd0, 8'h05, 8'h05, 8'h00, 8'h00, 8'hC0, 1'b1},
        {3'd2, 3'd0, 8'h01, 8'h02, 8'h00, 8'hFF, 8'h70, 1'b1},
        {3'd3, 3'd0, 8'h10, 8'h0F, 8'h13, 8'h00, 8'hE3, 1'b1},
        {3'd3, 3'd0, 8'h00, 8'h00, 8'h10, 8'hFF, 8'h70, 1'b1},
        {3'd4, 3'd0, 8'hF0, 8'h3C, 8'h10, 8'h30, 8'h20, 1'b1},
        {3'd4, 3'd0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'hA0, 1'b1},
        {3'd5, 3'd0, 8'h55, 8'hAA, 8'h70, 8'hFF, 8'h00, 1'b1},
        {3'd5, 3'd7, 8'h5A, 8'h33, 8'h00, 8'h00, 8'h80, 1'b1},
        {3'd6, 3'd0, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h8F, 1'b1},
        {3'd6, 3'd0, 8'h12, 8'h40, 8'h00, 8'h52, 8'h00, 1'b1},
        {3'd7, 3'd0, 8'h20, 8'h21, 8'h00, 8'h20, 8'h70, 1'b0},
        {3'd7, 3'd0, 8'h42, 8'h42, 8'h00, 8'h42, 8'hC0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [7:0]  instr = 8'h00;
    logic [7:0]  acc_in = 8'h00;
    logic [7:0]  flags_in = 8'h00;
    logic [47:0] gpr_flat = '0;
    logic [7:0]  mem_rdata;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic        acc_we;
    logic [7:0]  acc_wdata;
    logic        flag_we;
    logic [7:0]  flag_wdata;
    logic        pc_inc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory responder: data is a fixed function of the address.
    assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8];

    acc_alu_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .acc_in(acc_in), .flags_in(flags_in), .gpr_flat(gpr_flat),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .flag_we(flag_we),
        .flag_wdata(flag_wdata), .pc_inc(pc_inc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R6";
            3'd2, 3'd3: return "R7";
            3'd7:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    // Offer one byte for one cycle; return at the negedge after acceptance.
    task automatic offer(input logic [7:0] byte_v);
        @(negedge clk);
        instr = byte_v;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic watch_quiet(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            chk(!pc_inc && !mem_rd && !flag_we && !acc_we, req,
                {pc_inc, mem_rd, flag_we, acc_we}, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state of every output
        chk({mem_rd, acc_we, flag_we, pc_inc} == 4'b0 && mem_addr == 0 &&
            acc_wdata == 0 && flag_wdata == 0, "R10", {mem_rd, acc_we, flag_we, pc_inc}, 0);
        rst_n = 1'b1;

        // Table walk: register operands R3 R5 R6 R7 R8 R9, source codes R2
        for (int i = 0; i < NV; i++) begin
            acc_in   = VEC[i].a;
            flags_in = VEC[i].fin;
            gpr_flat = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55, VEC[i].b};
            if (VEC[i].src == 3'd7) gpr_flat[7:0] = 8'hC3;
            offer({2'b10, VEC[i].op, VEC[i].src});
            chk(pc_inc && flag_we && !mem_rd, "R3", {pc_inc, flag_we, mem_rd}, 3'b110);
            chk(flag_wdata == VEC[i].ef, req_of(VEC[i].op), flag_wdata, VEC[i].ef);
            chk(acc_we == VEC[i].ewe, "R8", acc_we, VEC[i].ewe);
            if (VEC[i].ewe)
                chk(acc_wdata == VEC[i].ea, req_of(VEC[i].op), acc_wdata, VEC[i].ea);
            @(negedge clk);
            chk(!pc_inc, "R3", pc_inc, 0);
        end

        // R2: each general register code picks its own field (add to zero)
        gpr_flat = {8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01};
        acc_in = 8'h00; flags_in = 8'h00;
        for (int s = 0; s < 6; s++) begin
            offer({2'b10, 3'd0, 3'(s)});
            chk(acc_wdata == 8'(s + 1), "R2", acc_wdata, s + 1);
        end

        // R1: bytes outside the group are ignored
        offer(8'h3E);
        watch_quiet(3, "R1");
        offer(8'hC1);
        watch_quiet(2, "R1");

        // R4: memory operand, second byte offered during the read cycle
        gpr_flat = {8'h34, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00};
        acc_in = 8'h10; flags_in = 8'h03;
        offer(8'h86);
        chk(mem_rd && !pc_inc, "R4", {mem_rd, pc_inc}, 2'b10);
        chk(mem_addr == 16'h1234, "R4", mem_addr, 16'h1234);
        instr = 8'h80; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(pc_inc && acc_we && !mem_rd, "R4", {pc_inc, acc_we, mem_rd}, 3'b110);
        chk(acc_wdata == 8'h36, "R4", acc_wdata, 8'h36);
        chk(flag_wdata == 8'h03, "R5", flag_wdata, 8'h03);
        @(negedge clk);
        watch_quiet(3, "R4");

        // R8 with memory: compare against the memory byte keeps acc unwritten
        acc_in = 8'h26; flags_in = 8'h00;
        offer(8'hBE);
        @(negedge clk);
        chk(pc_inc && !acc_we && flag_wdata == 8'hC0, "R8", flag_wdata, 8'hC0);

        // R10: reset during the read cycle abandons the instruction
        offer(8'h86);
        chk(mem_rd, "R4", mem_rd, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        watch_quiet(4, "R10");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule